// File: doc/BRIEF.md
# Interrupt and Test-Wait Front End

This block sits between the external interrupt and synchronisation pins and a processor core. It brings the asynchronous maskable request, the non-maskable request and the test input into the clock domain through two-flop synchronisers. It turns them into registered, prioritised indications for the core. When the core accepts a maskable interrupt, the block runs the two-pulse acknowledge sequence on an active-low acknowledge output and captures the vector byte from the data bus. It also holds instruction execution stalled after a WAIT instruction for as long as the test input stays high.

The maskable request is level sensitive. It is sampled only at instruction boundaries, and only while the core's interrupt-enable flag is set. A rising edge on the non-maskable request is caught in a sticky latch. That latch takes priority over the maskable request and is cleared only when the core accepts it. The active-low asynchronous reset clears all state. On the first clock after reset is released, the block gives a one-cycle pulse that starts the core's reset routine.

Top module: `irq_front_end`

## Requirements
- R1: While rst_ni is 0, reset_start_o, nmi_pend_o, intr_req_o, vector_valid_o and stall_o are 0 and ack_n_o is 1. reset_start_o is 1 for exactly the cycle after the first rising clock edge following reset release.
- R2: intr_i passes through a two-stage synchroniser. intr_req_o becomes 1 on the clock edge at which the synchronised request is 1, if_flag_i is 1 and insn_boundary_i is 1. Otherwise it stays 0: if_flag_i at 0 or insn_boundary_i at 0 leaves it unset.
- R3: A 0-to-1 transition of the synchronised nmi_i sets nmi_pend_o, whatever the state of if_flag_i and insn_boundary_i. nmi_pend_o stays 1 until irq_accept_i is 1 while it is 1. A level held high after acceptance does not set it again.
- R4: nmi_pend_o and intr_req_o are never 1 together. While a non-maskable request is pending, the maskable one is withheld. irq_accept_i applies to the non-maskable request when both kinds are present.
- R5: When irq_accept_i is 1 with intr_req_o at 1, ack_n_o goes low in the next cycle for PULSE_CYC cycles. It then stays high for GAP_CYC cycles, then goes low again for PULSE_CYC cycles.
- R6: On the clock edge that ends the second acknowledge pulse, data_i is captured into vector_o, and vector_valid_o is 1 for that one cycle.
- R7: intr_req_o stays 0 while an acknowledge sequence is running. It can be set again at the first instruction boundary after the sequence ends.
- R8: When wait_exec_i is 1 and the synchronised test_i is 1, stall_o is 1 from the next cycle. It stays 1 while the synchronised test_i remains 1.
- R9: Once test_i returns to 0, stall_o falls three clock edges later. A WAIT issued with the synchronised test_i at 0 does not raise stall_o.
- R10: Accepting a non-maskable request produces no acknowledge pulse: ack_n_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| intr_i | input | 1 | Maskable request, level sensitive, active high, asynchronous |
| nmi_i | input | 1 | Non-maskable request, rising-edge triggered, asynchronous |
| test_i | input | 1 | Test input; 1 keeps a WAIT stalled, asynchronous |
| if_flag_i | input | 1 | Core interrupt-enable flag |
| insn_boundary_i | input | 1 | Core is at an instruction boundary |
| wait_exec_i | input | 1 | Core is executing a WAIT instruction (one-cycle pulse) |
| irq_accept_i | input | 1 | Core accepts the indicated interrupt (one-cycle pulse) |
| data_i | input | VEC_W | Data bus carrying the vector byte |
| reset_start_o | output | 1 | One-cycle pulse that starts the reset routine |
| nmi_pend_o | output | 1 | Non-maskable request pending |
| intr_req_o | output | 1 | Maskable request recognised |
| ack_n_o | output | 1 | Interrupt acknowledge, active low |
| vector_o | output | VEC_W | Captured vector byte |
| vector_valid_o | output | 1 | vector_o updated this cycle |
| stall_o | output | 1 | Hold instruction execution |

## Verification
The assertions take for granted that irq_accept_i and wait_exec_i are single-cycle pulses. They also assume irq_accept_i is raised only while nmi_pend_o or intr_req_o is showing. The stimulus keeps to this by driving both strobes for exactly one clock, and only after it has seen the matching indication. The asynchronous pins are changed half a cycle away from the clock edge and held for at least two cycles, so every change passes through the synchronisers. The bench timing assumes exactly two synchroniser stages.

// File: rtl/irq_fe_pkg.sv
`timescale 1ns/1ps
package irq_fe_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_P1   = 2'd1,
    SEQ_GAP  = 2'd2,
    SEQ_P2   = 2'd3
  } ack_state_e;
endpackage

// File: rtl/irq_fe_sync.sv
`timescale 1ns/1ps
module irq_fe_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_fe_nmi_latch.sv
`timescale 1ns/1ps
module irq_fe_nmi_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_s_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q, pend_q, rise;

  assign rise = nmi_s_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= nmi_s_i;
      // a fresh edge wins over a same-cycle clear
      if (rise)       pend_q <= 1'b1;
      else if (clr_i) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_fe_ack_seq.sv
`timescale 1ns/1ps
module irq_fe_ack_seq
  import irq_fe_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 2,
  parameter int unsigned GAP_CYC   = 3,
  parameter int unsigned VEC_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [VEC_W-1:0] data_i,
  output logic             busy_o,
  output logic             ack_n_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_valid_o
);
  localparam int unsigned MAX_C = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
  localparam int unsigned CW    = $clog2(MAX_C + 1);
  localparam logic [CW-1:0] PULSE_LD = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] GAP_LD   = CW'(GAP_CYC - 1);

  ack_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic ack_n_q;
  logic [VEC_W-1:0] vec_q;
  logic vec_valid_q, capture;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    capture = 1'b0;
    unique case (state_q)
      SEQ_IDLE: if (start_i) begin
        state_d = SEQ_P1;
        cnt_d   = PULSE_LD;
      end
      SEQ_P1: begin
        if (cnt_q == '0) begin
          state_d = SEQ_GAP;
          cnt_d   = GAP_LD;
        end else cnt_d = cnt_q - 1'b1;
      end
      SEQ_GAP: begin
        if (cnt_q == '0) begin
          state_d = SEQ_P2;
          cnt_d   = PULSE_LD;
        end else cnt_d = cnt_q - 1'b1;
      end
      SEQ_P2: begin
        if (cnt_q == '0) begin
          state_d = SEQ_IDLE;
          capture = 1'b1;
        end else cnt_d = cnt_q - 1'b1;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= SEQ_IDLE;
      cnt_q       <= '0;
      ack_n_q     <= 1'b1;
      vec_q       <= '0;
      vec_valid_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      // registered so the pin never glitches on state decode
      ack_n_q     <= !((state_d == SEQ_P1) || (state_d == SEQ_P2));
      vec_valid_q <= capture;
      if (capture) vec_q <= data_i;
    end
  end

  assign busy_o      = (state_q != SEQ_IDLE);
  assign ack_n_o     = ack_n_q;
  assign vec_o       = vec_q;
  assign vec_valid_o = vec_valid_q;
endmodule

// File: rtl/irq_fe_wait_stall.sv
`timescale 1ns/1ps
module irq_fe_wait_stall (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_i,
  input  logic test_s_i,
  output logic stall_o
);
  logic stall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  stall_q <= 1'b0;
    else if (wait_i || stall_q)   stall_q <= test_s_i;
  end

  assign stall_o = stall_q;
endmodule

// File: rtl/irq_front_end.sv
`timescale 1ns/1ps
module irq_front_end #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PULSE_CYC   = 2,
  parameter int unsigned GAP_CYC     = 3,
  parameter int unsigned VEC_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             intr_i,
  input  logic             nmi_i,
  input  logic             test_i,
  input  logic             if_flag_i,
  input  logic             insn_boundary_i,
  input  logic             wait_exec_i,
  input  logic             irq_accept_i,
  input  logic [VEC_W-1:0] data_i,
  output logic             reset_start_o,
  output logic             nmi_pend_o,
  output logic             intr_req_o,
  output logic             ack_n_o,
  output logic [VEC_W-1:0] vector_o,
  output logic             vector_valid_o,
  output logic             stall_o
);
  localparam int unsigned NSYNC = 3;

  logic [NSYNC-1:0] raw, synced;
  logic intr_s, nmi_s, test_s;
  logic nmi_pend, seq_busy, accept_nmi, accept_intr;
  logic intr_req_q, boot_done_q, reset_start_q;

  assign raw    = {test_i, nmi_i, intr_i};
  assign intr_s = synced[0];
  assign nmi_s  = synced[1];
  assign test_s = synced[2];

  irq_fe_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  assign accept_nmi  = irq_accept_i & nmi_pend;
  assign accept_intr = irq_accept_i & intr_req_o;

  irq_fe_nmi_latch i_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nmi_s_i(nmi_s),
    .clr_i  (accept_nmi),
    .pend_o (nmi_pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) intr_req_q <= 1'b0;
    else if (nmi_pend || accept_intr) intr_req_q <= 1'b0;
    else if (insn_boundary_i && intr_s && if_flag_i && !seq_busy)
      intr_req_q <= 1'b1;
  end

  assign intr_req_o = intr_req_q & ~nmi_pend;
  assign nmi_pend_o = nmi_pend;

  irq_fe_ack_seq #(
    .PULSE_CYC(PULSE_CYC),
    .GAP_CYC  (GAP_CYC),
    .VEC_W    (VEC_W)
  ) i_ack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept_intr),
    .data_i     (data_i),
    .busy_o     (seq_busy),
    .ack_n_o    (ack_n_o),
    .vec_o      (vector_o),
    .vec_valid_o(vector_valid_o)
  );

  irq_fe_wait_stall i_wait (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wait_i  (wait_exec_i),
    .test_s_i(test_s),
    .stall_o (stall_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_done_q   <= 1'b0;
      reset_start_q <= 1'b0;
    end else begin
      boot_done_q   <= 1'b1;
      reset_start_q <= !boot_done_q;
    end
  end

  assign reset_start_o = reset_start_q;
endmodule

// File: rtl/irq_front_end_chk.sv
`timescale 1ns/1ps
module irq_front_end_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wait_exec_i,
  input logic irq_accept_i,
  input logic reset_start_o,
  input logic nmi_pend_o,
  input logic intr_req_o,
  input logic ack_n_o,
  input logic vector_valid_o,
  input logic stall_o
);
  // R1
  reset_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_start_o |=> !reset_start_o);

  // R3
  nmi_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_pend_o && !irq_accept_i) |=> nmi_pend_o);

  // R4
  pri_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({nmi_pend_o, intr_req_o}));

  // R5
  ack_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intr_req_o && irq_accept_i) |=> !ack_n_o);

  // R6
  vec_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vector_valid_o |-> (ack_n_o && !$past(ack_n_o)));

  // R7
  no_req_in_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_n_o |-> !intr_req_o);

  // R8
  stall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> $past(wait_exec_i));

  // R10
  nmi_no_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_n_o && nmi_pend_o && irq_accept_i) |=> ack_n_o);
endmodule

bind irq_front_end irq_front_end_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wait_exec_i   (wait_exec_i),
  .irq_accept_i  (irq_accept_i),
  .reset_start_o (reset_start_o),
  .nmi_pend_o    (nmi_pend_o),
  .intr_req_o    (intr_req_o),
  .ack_n_o       (ack_n_o),
  .vector_valid_o(vector_valid_o),
  .stall_o       (stall_o)
);

// File: tb/test_irq_front_end.sv
`timescale 1ns/1ps
module test_irq_front_end;
  localparam int P = 2;
  localparam int G = 3;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic intr_i = 0, nmi_i = 0, test_i = 0, if_flag_i = 0, insn_boundary_i = 0;
  logic wait_exec_i = 0, irq_accept_i = 0;
  logic [W-1:0] data_i = '0;
  logic reset_start_o, nmi_pend_o, intr_req_o, ack_n_o, vector_valid_o, stall_o;
  logic [W-1:0] vector_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_front_end #(.PULSE_CYC(P), .GAP_CYC(G), .VEC_W(W)) i_irq_front_end (
    .clk_i(clk), .rst_ni(rst_ni), .intr_i(intr_i), .nmi_i(nmi_i), .test_i(test_i),
    .if_flag_i(if_flag_i), .insn_boundary_i(insn_boundary_i),
    .wait_exec_i(wait_exec_i), .irq_accept_i(irq_accept_i), .data_i(data_i),
    .reset_start_o(reset_start_o), .nmi_pend_o(nmi_pend_o), .intr_req_o(intr_req_o),
    .ack_n_o(ack_n_o), .vector_o(vector_o), .vector_valid_o(vector_valid_o),
    .stall_o(stall_o)
  );

  // {intr, if_flag, boundary, expected request} , vector byte
  localparam logic [11:0] ROWS [5] = '{12'hFA5, 12'hA00, 12'hC00, 12'h600, 12'hF3C};

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // accept an indicated maskable request and check the full pulse train
  task automatic run_ack(input logic [W-1:0] vec, input bit watch_req, input string tag);
    data_i = vec;
    irq_accept_i = 1'b1;
    tick();
    irq_accept_i = 1'b0;
    for (int k = 0; k <= 2*P+G; k++) begin
      bit low;
      low = (k < P) || (k >= P+G && k < 2*P+G);
      chk(ack_n_o == !low, "R5", ack_n_o, !low);
      if (watch_req) chk(intr_req_o == 1'b0, "R7", intr_req_o, 0);
      if (k == 2*P+G) begin
        chk(vector_valid_o == 1'b1, "R6", vector_valid_o, 1);
        chk(vector_o == vec, "R6", vector_o, vec);
      end else chk(vector_valid_o == 1'b0, "R6", vector_valid_o, 0);
      if (k < 2*P+G) tick();
    end
    if (tag.len() > 0) begin
      tick();
      chk(intr_req_o == 1'b1, tag, intr_req_o, 1);
    end
  endtask

  initial begin
    #3;
    // R1 reset state
    chk(ack_n_o == 1'b1, "R1", ack_n_o, 1);
    chk({reset_start_o, nmi_pend_o, intr_req_o, vector_valid_o, stall_o} == '0, "R1",
        {reset_start_o, nmi_pend_o, intr_req_o, vector_valid_o, stall_o}, 0);
    rst_ni = 1'b1;
    tick();
    chk(reset_start_o == 1'b1, "R1", reset_start_o, 1);
    tick();
    chk(reset_start_o == 1'b0, "R1", reset_start_o, 0);
    tick(2);

    // R2 gating table
    for (int r = 0; r < 5; r++) begin
      {intr_i, if_flag_i, insn_boundary_i} = ROWS[r][11:9];
      tick(4);
      chk(intr_req_o == ROWS[r][8], "R2", intr_req_o, ROWS[r][8]);
      intr_i = 1'b0;
      insn_boundary_i = 1'b0;
      if (ROWS[r][8]) run_ack(ROWS[r][7:0], 1'b0, "");
      tick(3);
    end

    // R3 NMI latches with no boundary and interrupts disabled, stays sticky
    if_flag_i = 0;
    insn_boundary_i = 0;
    nmi_i = 1;
    tick(2);
    nmi_i = 0;
    chk(nmi_pend_o == 1'b0, "R3", nmi_pend_o, 0);
    tick(2);
    chk(nmi_pend_o == 1'b1, "R3", nmi_pend_o, 1);
    tick(6);
    chk(nmi_pend_o == 1'b1, "R3", nmi_pend_o, 1);
    irq_accept_i = 1;
    tick();
    irq_accept_i = 0;
    chk(nmi_pend_o == 1'b0, "R3", nmi_pend_o, 0);
    chk(ack_n_o == 1'b1, "R10", ack_n_o, 1);
    tick(3);

    // R4 simultaneous requests: NMI shown first, maskable withheld
    intr_i = 1; nmi_i = 1; if_flag_i = 1; insn_boundary_i = 1;
    tick(4);
    chk(nmi_pend_o == 1'b1, "R4", nmi_pend_o, 1);
    chk(intr_req_o == 1'b0, "R4", intr_req_o, 0);
    irq_accept_i = 1;
    tick();
    irq_accept_i = 0;
    chk(nmi_pend_o == 1'b0, "R4", nmi_pend_o, 0);
    chk(intr_req_o == 1'b0, "R4", intr_req_o, 0);
    for (int k = 0; k < 4; k++) begin
      chk(ack_n_o == 1'b1, "R10", ack_n_o, 1);
      tick();
    end
    chk(intr_req_o == 1'b1, "R4", intr_req_o, 1);
    // R7 request held high through a sequence, re-raised after it
    run_ack(8'h77, 1'b1, "R7");
    intr_i = 0;
    chk(nmi_pend_o == 1'b0, "R3", nmi_pend_o, 0);
    run_ack(8'h81, 1'b0, "");
    tick(3);
    chk(intr_req_o == 1'b0, "R2", intr_req_o, 0);
    chk(nmi_pend_o == 1'b0, "R3", nmi_pend_o, 0);
    nmi_i = 0;
    insn_boundary_i = 0;
    tick(3);

    // R8 / R9 WAIT against TEST
    test_i = 1;
    tick(3);
    wait_exec_i = 1;
    tick();
    wait_exec_i = 0;
    chk(stall_o == 1'b1, "R8", stall_o, 1);
    tick(5);
    chk(stall_o == 1'b1, "R8", stall_o, 1);
    test_i = 0;
    tick(2);
    chk(stall_o == 1'b1, "R9", stall_o, 1);
    tick();
    chk(stall_o == 1'b0, "R9", stall_o, 0);
    tick(2);
    wait_exec_i = 1;
    tick();
    wait_exec_i = 0;
    chk(stall_o == 1'b0, "R9", stall_o, 0);
    tick(2);
    chk(stall_o == 1'b0, "R9", stall_o, 0);

    // R1 asynchronous reset mid-run
    nmi_i = 1;
    tick(4);
    nmi_i = 0;
    chk(nmi_pend_o == 1'b1, "R3", nmi_pend_o, 1);
    #1 rst_ni = 0;
    #1;
    chk(nmi_pend_o == 1'b0, "R1", nmi_pend_o, 0);
    tick();
    rst_ni = 1;
    tick();
    chk(reset_start_o == 1'b1, "R1", reset_start_o, 1);
    tick(3);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule